// File: doc/BRIEF.md
# Normalize Shift Amount Unit

This block takes a 32-bit word and returns how many places it must move left to be normalised. It has two functions. The unsigned function counts leading zero bits. The signed function counts the bits below the most significant bit that repeat the sign, which gives the left shift that puts a two's-complement value into normal form. The block reports only the amount. The caller performs the shift and derives any flags it needs.

A one-bit opcode picks the function for each input word. A parameter decides whether the result appears in the same cycle or one cycle later from a register stage. A valid strobe travels alongside the data. The count comes from a balanced tree of pairwise merges, so the logic depth grows with the logarithm of the word width and not with the width itself.

Top module: `norm_shift_unit`

## Requirements
- R1: `in_op` picks the function: 0 selects the unsigned count and 1 selects the signed count. The same word can give different results under the two functions.
- R2: Unsigned function, nonzero word: `out_amount` equals the number of zero bits above the highest set bit (0 to 31).
- R3: Unsigned function, word 0x00000000: `out_amount` is 32.
- R4: Signed function: a word with bit 31 set is first inverted bit by bit. The result is the leading-zero count of that word minus one, which equals the number of bits below bit 31 that equal bit 31 before the first bit that differs.
- R5: Signed function, word 0x00000000 or 0xFFFFFFFF: `out_amount` is 31.
- R6: Signed function: the result never exceeds 31, and it is 0 whenever bit 30 differs from bit 31.
- R7: With `REG_OUT`=1 the result and `out_valid` appear one clock after the input is presented, and `out_valid` is `in_valid` delayed by one clock. With `REG_OUT`=0 both follow the inputs in the same cycle.
- R8: With `REG_OUT`=1, a clock edge with `rst_n` low clears `out_valid` and `out_amount` to 0.
- R9: With `REG_OUT`=1, a clock edge with `in_valid` low leaves `out_amount` unchanged, whatever `in_data` and `in_op` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input word is valid |
| in_op | input | 1 | Function select: 0 unsigned, 1 signed |
| in_data | input | 32 | Word to be measured |
| out_valid | output | 1 | Result is valid |
| out_amount | output | 6 | Normalising left-shift amount |

## Verification
The bench builds two copies of the block side by side at the default 32-bit width, one with `REG_OUT`=1 and one with `REG_OUT`=0. They receive the same stimulus. The combinational copy is checked in the cycle the inputs are applied, and the registered copy is checked one edge later. This covers both latency variants, the reset clear, and the hold on idle cycles. Every single-bit word and its negation is applied under both functions, so each input of the merge tree, and each carry of its count, appears as the leading bit at least once.

// File: rtl/nsa_pkg.sv
// Package: shared definitions for the normalize shift amount unit.
// Assumes: word width is a power of two.
package nsa_pkg;

    localparam int unsigned WORD_W = 32;

    // Function select encoding carried on in_op.
    typedef enum logic {
        OP_UNSIGNED = 1'b0,
        OP_SIGNED   = 1'b1
    } nsa_op_e;

endpackage

// File: rtl/nsa_condition.sv
// Module: nsa_condition
// Conditions the word before counting. In signed mode a negative word is
// inverted, so copies of the sign bit become leading zeros.
// Assumes: purely combinational; the caller supplies the mode bit.
module nsa_condition #(
    parameter int unsigned W = 32
) (
    input  logic         signed_mode,
    input  logic [W-1:0] word,
    output logic [W-1:0] cond
);

    // Purpose: invert negative words in signed mode, pass others unchanged.
    always_comb begin
        if (signed_mode && word[W-1]) begin
            cond = ~word;
        end else begin
            cond = word;
        end
    end

endmodule

// File: rtl/nsa_lzc_tree.sv
// Module: nsa_lzc_tree
// Leading-zero counter built as a balanced binary tree. Each node merges
// two halves: if the upper half is all zero, the count is the half size
// plus the lower count, otherwise the upper count is taken.
// Assumes: W is a power of two; an all-zero vector yields W.
module nsa_lzc_tree #(
    parameter int unsigned W  = 32,
    parameter int unsigned CW = $clog2(W) + 1
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] count
);

    localparam int unsigned LV = $clog2(W);

    logic [CW-1:0] cnt  [LV+1][W];
    logic          zflg [LV+1][W];

    genvar lv, n;

    // Leaf level: each bit is a group of one.
    generate
        for (n = 0; n < W; n++) begin : g_leaf
            // Purpose: a clear bit counts one zero and marks its group empty.
            always_comb begin
                cnt[0][n]  = {{(CW-1){1'b0}}, ~vec[n]};
                zflg[0][n] = ~vec[n];
            end
        end
    endgenerate

    // Merge levels: node n at level lv covers bits n*2^lv up to (n+1)*2^lv-1.
    generate
        for (lv = 1; lv <= LV; lv++) begin : g_level
            localparam logic [CW-1:0] HALF = CW'(1) << (lv - 1);
            for (n = 0; n < W; n++) begin : g_node
                if (n < (W >> lv)) begin : g_used
                    // Purpose: merge the upper (2n+1) and lower (2n) child groups.
                    always_comb begin
                        zflg[lv][n] = zflg[lv-1][2*n+1] & zflg[lv-1][2*n];
                        if (zflg[lv-1][2*n+1]) begin
                            cnt[lv][n] = HALF + cnt[lv-1][2*n];
                        end else begin
                            cnt[lv][n] = cnt[lv-1][2*n+1];
                        end
                    end
                end else begin : g_unused
                    // Purpose: tie off slots this level does not need.
                    always_comb begin
                        cnt[lv][n]  = '0;
                        zflg[lv][n] = 1'b0;
                    end
                end
            end
        end
    endgenerate

    assign count = cnt[LV][0];

endmodule

// File: rtl/norm_shift_unit.sv
// Module: norm_shift_unit (top)
// Returns the normalising left-shift amount of a word: the leading-zero
// count (unsigned) or the redundant sign bit count (signed). REG_OUT picks
// a same-cycle result or a registered result that has one cycle of latency.
// Assumes: synchronous active-low reset; W is a power of two.
module norm_shift_unit #(
    parameter int unsigned W       = nsa_pkg::WORD_W,
    parameter bit          REG_OUT = 1'b1,
    parameter int unsigned CW      = $clog2(W) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_op,
    input  logic [W-1:0]  in_data,
    output logic          out_valid,
    output logic [CW-1:0] out_amount
);

    import nsa_pkg::*;

    localparam logic [CW-1:0] FULL_CNT = CW'(W);
    localparam logic [CW-1:0] MAX_SGN  = CW'(W - 1);

    nsa_op_e       op_sel;
    logic          sgn_mode;
    logic [W-1:0]  cond_word;
    logic [CW-1:0] lz_count;
    logic [CW-1:0] amount_c;

    // Purpose: decode the function select.
    always_comb begin
        op_sel   = nsa_op_e'(in_op);
        sgn_mode = (op_sel == OP_SIGNED);
    end

    nsa_condition #(.W(W)) u_cond (
        .signed_mode (sgn_mode),
        .word        (in_data),
        .cond        (cond_word)
    );

    nsa_lzc_tree #(.W(W), .CW(CW)) u_tree (
        .vec   (cond_word),
        .count (lz_count)
    );

    // Purpose: the signed count drops the sign bit itself from the count.
    always_comb begin
        if (sgn_mode) begin
            amount_c = lz_count - CW'(1);
        end else begin
            amount_c = lz_count;
        end
    end

    generate
        if (REG_OUT) begin : g_reg
            // Purpose: register the result and valid; hold the result on idle cycles.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    out_valid  <= 1'b0;
                    out_amount <= '0;
                end else begin
                    out_valid <= in_valid;
                    if (in_valid) begin
                        out_amount <= amount_c;
                    end
                end
            end

            assert_unsigned_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && !in_op && in_data == '0) |=> (out_amount == FULL_CNT));
            assert_signed_flat_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && in_op && (in_data == '0 || in_data == '1)) |=> (out_amount == MAX_SGN));
            assert_signed_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && in_op) |=> (out_amount <= MAX_SGN));
            assert_valid_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid);
            assert_valid_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> !out_valid);
            assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> $stable(out_amount));
        end else begin : g_comb
            // Purpose: pass the result straight through.
            always_comb begin
                out_valid  = in_valid;
                out_amount = amount_c;
            end

            assert_unsigned_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && !in_op && in_data == '0) |-> (out_amount == FULL_CNT));
            assert_signed_flat_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && in_op && (in_data == '0 || in_data == '1)) |-> (out_amount == MAX_SGN));
            assert_signed_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && in_op) |-> (out_amount <= MAX_SGN));
            assert_msb_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && !in_op && in_data[W-1]) |-> (out_amount == '0));
        end
    endgenerate

endmodule

// File: tb/norm_shift_unit_bench.sv
`timescale 1ns/1ps
module norm_shift_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_op = 1'b0;
    logic [31:0] in_data = '0;
    logic        r_valid, c_valid;
    logic [5:0]  r_amount, c_amount;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    norm_shift_unit #(.W(32), .REG_OUT(1'b1)) u_norm_shift_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_data(in_data), .out_valid(r_valid), .out_amount(r_amount)
    );

    norm_shift_unit #(.W(32), .REG_OUT(1'b0)) u_norm_shift_unit_comb (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_data(in_data), .out_valid(c_valid), .out_amount(c_amount)
    );

    function automatic int ref_clz(logic [31:0] v);
        for (int i = 31; i >= 0; i--) begin
            if (v[i]) return 31 - i;
        end
        return 32;
    endfunction

    function automatic int ref_amount(logic op, logic [31:0] v);
        logic [31:0] u;
        if (op) begin
            u = v[31] ? ~v : v;
            return ref_clz(u) - 1;
        end
        return ref_clz(v);
    endfunction

    function automatic string pick_tag(logic op, logic [31:0] v);
        if (!op) return (v == 0) ? "R3" : "R2";
        if (v == 32'h0 || v == 32'hFFFF_FFFF) return "R5";
        if (v[31] != v[30]) return "R6";
        return "R4";
    endfunction

    task automatic check(string tag, int actual, int expected, string what);
        checks++;
        if (actual != expected) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, actual, expected);
        end
    endtask

    // Apply one word; check the same-cycle copy now and the registered copy after the edge.
    task automatic run_vec(logic op, logic [31:0] v, string tag);
        int exp_amt;
        exp_amt = ref_amount(op, v);
        @(negedge clk);
        in_valid = 1'b1;
        in_op    = op;
        in_data  = v;
        #1;
        check(tag, int'(c_amount), exp_amt, "comb amount");
        check("R7", int'(c_valid), 1, "comb valid same cycle");
        @(posedge clk);
        #1;
        check(tag, int'(r_amount), exp_amt, "reg amount");
        check("R7", int'(r_valid), 1, "reg valid after one edge");
    endtask

    // Idle cycle with noisy inputs: registered result must hold.
    task automatic run_idle(logic [31:0] noise);
        logic [5:0] prev;
        @(negedge clk);
        prev     = r_amount;
        in_valid = 1'b0;
        in_op    = ~in_op;
        in_data  = noise;
        #1;
        check("R7", int'(c_valid), 0, "comb valid low");
        @(posedge clk);
        #1;
        check("R9", int'(r_amount), int'(prev), "reg amount hold");
        check("R7", int'(r_valid), 0, "reg valid low");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8", int'(r_valid), 0, "reset valid");
        check("R8", int'(r_amount), 0, "reset amount");
        rst_n = 1'b1;

        run_vec(1'b0, 32'h0000_0000, "R3");
        run_vec(1'b1, 32'h0000_0000, "R5");
        run_vec(1'b1, 32'hFFFF_FFFF, "R5");
        run_vec(1'b0, 32'hFFFF_FFFF, "R2");
        run_vec(1'b0, 32'h00F0_0000, "R1");
        run_vec(1'b1, 32'h00F0_0000, "R1");
        run_vec(1'b1, 32'h7FFF_FFFF, "R6");
        run_vec(1'b1, 32'h8000_0000, "R6");
        run_idle(32'h0000_0001);

        for (int b = 0; b < 32; b++) begin
            for (int o = 0; o < 2; o++) begin
                logic [31:0] p, q;
                p = 32'h1 << b;
                q = -p;
                run_vec(o[0], p, pick_tag(o[0], p));
                run_vec(o[0], q, pick_tag(o[0], q));
            end
        end

        void'($urandom(32'd7331));
        for (int k = 0; k < 300; k++) begin
            logic [31:0] v;
            logic op;
            v  = $urandom() >> ($urandom() % 32);
            if ($urandom() % 2) v = ~v;
            op = 1'($urandom());
            run_vec(op, v, pick_tag(op, v));
            if (k % 25 == 0) run_idle($urandom());
        end

        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b1;
        @(posedge clk);
        #1;
        check("R8", int'(r_valid), 0, "mid-run reset valid");
        check("R8", int'(r_amount), 0, "mid-run reset amount");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R7 watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule